// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupt Detection

This block is a memory-mapped general-purpose I/O controller for up to `NPINS` pins (32 by default). Through a single-cycle register port (word address, write strobe, write data, combinational read data) software programs which pins are driven. It changes output levels either through dedicated set and clear registers or by writing the whole output word. It reads back the sampled pin levels.

Every input pin passes through a two-flop synchroniser. It then goes through an optional debounce filter, selected per pin, that is clocked by an external sample strobe. The chosen value feeds a per-pin interrupt detector. Three independent bit registers select level or edge detection, single or both edges, and the active polarity. Edge events are latched until software writes a 1 to the clear register. Level events follow the pin. The raw status is qualified by an enable and a mask, and the masked bits are ORed into a single interrupt line.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every readable register (words 0, 3, 5 to 11 and 13) reads 0, `pin_oe` and `pin_out` are 0 and `irq` is low.
- R2: Word 0 holds the direction bits; `pin_oe` equals this register, so a 1 makes that pin an output.
- R3: Writing word 1 sets the output bits where the data has a 1, and writing word 2 clears them; 0 bits leave those outputs alone. Writing word 3 replaces the whole output word, which `pin_out` shows and word 3 reads back.
- R4: Word 4 returns each pin's input level two clock cycles after it is presented, or its filtered level when debounce is enabled for that pin.
- R5: With the enable bit set (word 5), the sense bit 0 (word 6, 1 = level), the both-edge bit 0 (word 7) and the polarity bit 1 (word 8), a rising edge sets that pin's raw status bit (word 9). The bit stays set after the pin falls again.
- R6: With polarity 0 in edge mode, only a falling edge sets the raw status bit.
- R7: With the both-edge bit set, either edge sets the raw status bit, whatever the polarity bit holds.
- R8: In level mode the raw status bit follows the pin: it is 1 while the pin equals the polarity bit (1 = high active, 0 = low active), and writes to the clear register do not change it.
- R9: A mask bit of 1 (word 10) hides a pin from the masked status (word 11) and from `irq` but not from the raw status. `irq` is high exactly when some masked status bit is 1.
- R10: A pin whose enable bit is 0 never sets its raw status, whatever edges or levels it sees.
- R11: Writing 1 to a bit of word 12 clears that pin's latched edge status; 0 bits have no effect.
- R12: With debounce enabled for a pin (word 13), the filtered value takes a new synchronised level only after `DB_TICKS` `db_tick` strobes during which the level has not returned to the old value; a return restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| bus_addr | input | 4 | Register word index |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| db_tick | input | 1 | Debounce sample strobe |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output levels |
| pin_oe | output | NPINS | Output enables |
| irq | output | 1 | OR of the masked status |

## Verification
The bench builds the controller with its defaults, `NPINS` = 32 and `DB_TICKS` = 4. The full width puts the top pin (bit 31) within reach, and both-edge detection is tested there. Four ticks keeps the filter short enough to show both an accepted change and a count that restarts when the level bounces back. The detection pins use all five trigger settings at once, so the sense, polarity and both-edge registers are checked against each other and not one pin at a time.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    RG_DIR   = 4'd0,
    RG_SET   = 4'd1,
    RG_CLR   = 4'd2,
    RG_OUT   = 4'd3,
    RG_IN    = 4'd4,
    RG_IEN   = 4'd5,
    RG_SENSE = 4'd6,
    RG_BOTH  = 4'd7,
    RG_POL   = 4'd8,
    RG_RAW   = 4'd9,
    RG_MASK  = 4'd10,
    RG_MIS   = 4'd11,
    RG_ICLR  = 4'd12,
    RG_DBEN  = 4'd13
  } gpio_reg_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end

  assign sync_o = stab_q;

endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int W        = 32,
  parameter int DB_TICKS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);

  localparam int CW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DB_TICKS - 1);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic          lvl_q, lvl_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
      lvl_d = lvl_q;
      cnt_d = cnt_q;
      if (din_i[i] == lvl_q) begin
        cnt_d = '0;
      end else if (tick_i) begin
        if (cnt_q == CNT_LAST) begin
          lvl_d = din_i[i];
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lvl_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        lvl_q <= lvl_d;
        cnt_q <= cnt_d;
      end
    end

    assign dout_o[i] = lvl_q;
  end

  // R12: the filtered level can only move on a sample strobe
  assert_db_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(dout_o));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] ien_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] mask_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] mis_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] latch_q, latch_d;
  logic [W-1:0] hit;
  logic [W-1:0] lvl_act;

  for (genvar i = 0; i < W; i++) begin : g_det
    logic rise, fall, edge_sel;
    assign rise     = lvl_i[i] & ~prev_q[i];
    assign fall     = ~lvl_i[i] & prev_q[i];
    assign edge_sel = both_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
    assign hit[i]     = ien_i[i] & ~sense_i[i] & edge_sel;
    assign lvl_act[i] = ien_i[i] & (lvl_i[i] == pol_i[i]);
    assign raw_o[i]   = sense_i[i] ? lvl_act[i] : latch_q[i];
  end

  always_comb begin
    latch_d = (latch_q & ~clr_i) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= lvl_i;
      latch_q <= latch_d;
    end
  end

  assign mis_o = raw_o & ien_i & ~mask_i;

  // R5: a detected edge is held in the latch on the following cycle
  assert_edge_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((latch_q & $past(hit)) == $past(hit)));

  // R11: a write-1 clear without a fresh edge empties the latch bit
  assert_clear_works_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~hit)) |=> ((latch_q & $past(clr_i & ~hit)) == '0));

  // R10: disabled pins never latch an edge
  assert_disabled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & ~ien_i) == '0));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int DB_TICKS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic              db_tick,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq
);

  gpio_reg_e reg_sel;
  assign reg_sel = gpio_reg_e'(bus_addr);

  logic [NPINS-1:0] dir_q,   dir_d;
  logic [NPINS-1:0] out_q,   out_d;
  logic [NPINS-1:0] ien_q,   ien_d;
  logic [NPINS-1:0] sense_q, sense_d;
  logic [NPINS-1:0] both_q,  both_d;
  logic [NPINS-1:0] pol_q,   pol_d;
  logic [NPINS-1:0] mask_q,  mask_d;
  logic [NPINS-1:0] dben_q,  dben_d;
  logic [NPINS-1:0] iclr;
  logic             cfg_en;

  logic [NPINS-1:0] pin_sync, pin_filt, pin_sel;
  logic [NPINS-1:0] raw_st, mis_st;

  assign cfg_en = bus_we;

  always_comb begin
    dir_d   = dir_q;
    out_d   = out_q;
    ien_d   = ien_q;
    sense_d = sense_q;
    both_d  = both_q;
    pol_d   = pol_q;
    mask_d  = mask_q;
    dben_d  = dben_q;
    iclr    = '0;
    if (bus_we) begin
      case (reg_sel)
        RG_DIR:   dir_d   = bus_wdata;
        RG_SET:   out_d   = out_q | bus_wdata;
        RG_CLR:   out_d   = out_q & ~bus_wdata;
        RG_OUT:   out_d   = bus_wdata;
        RG_IEN:   ien_d   = bus_wdata;
        RG_SENSE: sense_d = bus_wdata;
        RG_BOTH:  both_d  = bus_wdata;
        RG_POL:   pol_d   = bus_wdata;
        RG_MASK:  mask_d  = bus_wdata;
        RG_ICLR:  iclr    = bus_wdata;
        RG_DBEN:  dben_d  = bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '0;
      out_q   <= '0;
      ien_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
      dben_q  <= '0;
    end else if (cfg_en) begin
      dir_q   <= dir_d;
      out_q   <= out_d;
      ien_q   <= ien_d;
      sense_q <= sense_d;
      both_q  <= both_d;
      pol_q   <= pol_d;
      mask_q  <= mask_d;
      dben_q  <= dben_d;
    end
  end

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (pin_sync)
  );

  gpio_debounce #(.W(NPINS), .DB_TICKS(DB_TICKS)) u_deb (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (db_tick),
    .din_i  (pin_sync),
    .dout_o (pin_filt)
  );

  assign pin_sel = (dben_q & pin_filt) | (~dben_q & pin_sync);

  gpio_irq_detect #(.W(NPINS)) u_det (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (pin_sel),
    .ien_i   (ien_q),
    .sense_i (sense_q),
    .both_i  (both_q),
    .pol_i   (pol_q),
    .mask_i  (mask_q),
    .clr_i   (iclr),
    .raw_o   (raw_st),
    .mis_o   (mis_st)
  );

  always_comb begin
    case (reg_sel)
      RG_DIR:   bus_rdata = dir_q;
      RG_OUT:   bus_rdata = out_q;
      RG_IN:    bus_rdata = pin_sel;
      RG_IEN:   bus_rdata = ien_q;
      RG_SENSE: bus_rdata = sense_q;
      RG_BOTH:  bus_rdata = both_q;
      RG_POL:   bus_rdata = pol_q;
      RG_RAW:   bus_rdata = raw_st;
      RG_MASK:  bus_rdata = mask_q;
      RG_MIS:   bus_rdata = mis_st;
      RG_DBEN:  bus_rdata = dben_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |mis_st;

  // R2: a direction write shows on the output enables next cycle
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && reg_sel == RG_DIR) |=> (pin_oe == $past(bus_wdata)));

  // R3: set-register ones are driven high next cycle
  assert_set_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && reg_sel == RG_SET) |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R3: clear-register ones are driven low next cycle
  assert_clr_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && reg_sel == RG_CLR) |=> ((pin_out & $past(bus_wdata)) == '0));

  // R9: the interrupt line only rises for an unmasked raw event
  assert_irq_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|(raw_st & ien_q & ~mask_q)));

endmodule

// File: tb/gpio_irq_ctrl_tb_top.sv
module gpio_irq_ctrl_tb_top;
  import gpio_irq_pkg::*;

  localparam int NPINS = 32;
  localparam int KIND_RD  = 0;
  localparam int KIND_IRQ = 1;
  localparam int KIND_OUT = 2;
  localparam int KIND_OE  = 3;

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  logic              clk;
  logic              rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic              bus_we;
  logic [NPINS-1:0]  bus_wdata;
  logic [NPINS-1:0]  bus_rdata;
  logic              db_tick;
  logic [NPINS-1:0]  pin_in;
  logic [NPINS-1:0]  pin_out;
  logic [NPINS-1:0]  pin_oe;
  logic              irq;

  exp_item_t sb_q[$];
  logic      mon_fire;
  int        n_checks;
  int        n_fail;
  bit        done;

  gpio_irq_ctrl #(.NPINS(NPINS), .DB_TICKS(4)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .db_tick   (db_tick),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // monitor: pops one expected item per request, samples on the falling edge
  always @(negedge clk) begin
    if (mon_fire && sb_q.size() > 0) begin
      exp_item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        KIND_RD:  act = bus_rdata;
        KIND_IRQ: act = {31'd0, irq};
        KIND_OUT: act = pin_out;
        default:  act = pin_oe;
      endcase
      n_checks++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(input gpio_reg_e a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_addr  = a;
    bus_we    = 1'b1;
    bus_wdata = d;
    @(posedge clk); #1;
    bus_we    = 1'b0;
  endtask

  task automatic expect_item(input int kind, input gpio_reg_e a,
                             input logic [31:0] e, input string tag);
    exp_item_t it;
    @(posedge clk); #1;
    bus_addr = a;
    it.kind = kind;
    it.exp  = e;
    it.tag  = tag;
    sb_q.push_back(it);
    mon_fire = 1'b1;
    @(negedge clk); #1;
    mon_fire = 1'b0;
  endtask

  task automatic rd(input gpio_reg_e a, input logic [31:0] e, input string tag);
    expect_item(KIND_RD, a, e, tag);
  endtask

  task automatic set_pin(input int idx, input logic v);
    @(posedge clk); #1;
    pin_in[idx] = v;
  endtask

  task automatic pulse_tick(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      db_tick = 1'b1;
      @(posedge clk); #1;
      db_tick = 1'b0;
    end
  endtask

  initial begin
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_we    = 1'b0;
    bus_wdata = '0;
    db_tick   = 1'b0;
    pin_in    = '0;
    mon_fire  = 1'b0;
    n_checks  = 0;
    n_fail    = 0;
    done      = 1'b0;
    idle(5);
    #1 rst_n = 1'b1;
    idle(2);

    // R1: reset state
    rd(RG_DIR,  32'h0, "R1 dir");
    rd(RG_OUT,  32'h0, "R1 out");
    rd(RG_IEN,  32'h0, "R1 ien");
    rd(RG_RAW,  32'h0, "R1 raw");
    rd(RG_MIS,  32'h0, "R1 mis");
    rd(RG_MASK, 32'h0, "R1 mask");
    rd(RG_DBEN, 32'h0, "R1 dben");
    expect_item(KIND_IRQ, RG_DIR, 32'h0, "R1 irq");
    expect_item(KIND_OE,  RG_DIR, 32'h0, "R1 oe");

    // R2: direction
    wr(RG_DIR, 32'hFFFF_0000);
    expect_item(KIND_OE, RG_DIR, 32'hFFFF_0000, "R2 oe");
    rd(RG_DIR, 32'hFFFF_0000, "R2 readback");

    // R3: set / clear / direct write
    wr(RG_SET, 32'h0000_F0F0);
    expect_item(KIND_OUT, RG_OUT, 32'h0000_F0F0, "R3 set");
    wr(RG_CLR, 32'h0000_3030);
    expect_item(KIND_OUT, RG_OUT, 32'h0000_C0C0, "R3 clr");
    wr(RG_SET, 32'h0);
    expect_item(KIND_OUT, RG_OUT, 32'h0000_C0C0, "R3 zero set");
    wr(RG_OUT, 32'h1234_5678);
    rd(RG_OUT, 32'h1234_5678, "R3 direct");

    // R4: input sampling
    @(posedge clk); #1 pin_in = 32'h00A5_0F00;
    idle(3);
    rd(RG_IN, 32'h00A5_0F00, "R4 input");
    @(posedge clk); #1 pin_in = '0;
    idle(3);

    // trigger setup: pin0 rising, pin1 falling, pin3 level high,
    // pin4 level low, pin31 both edges (polarity 1 ignored)
    wr(RG_SENSE, 32'h0000_0018);
    wr(RG_BOTH,  32'h8000_0000);
    wr(RG_POL,   32'h8000_0009);
    wr(RG_IEN,   32'h8000_001B);
    rd(RG_RAW, 32'h0000_0010, "R8 low active");
    rd(RG_MIS, 32'h0000_0010, "R9 mis");
    expect_item(KIND_IRQ, RG_MIS, 32'h1, "R9 irq on");

    wr(RG_MASK, 32'h0000_0010);
    rd(RG_RAW, 32'h0000_0010, "R9 raw under mask");
    rd(RG_MIS, 32'h0, "R9 masked");
    expect_item(KIND_IRQ, RG_MIS, 32'h0, "R9 irq off");

    // R5: rising edge
    set_pin(0, 1'b1); idle(4);
    rd(RG_RAW, 32'h0000_0011, "R5 rise");
    expect_item(KIND_IRQ, RG_MIS, 32'h1, "R5 irq");
    set_pin(0, 1'b0); idle(4);
    rd(RG_RAW, 32'h0000_0011, "R5 held");
    wr(RG_ICLR, 32'h1);
    rd(RG_RAW, 32'h0000_0010, "R11 clear");
    expect_item(KIND_IRQ, RG_MIS, 32'h0, "R11 irq");

    // R6: falling edge
    set_pin(1, 1'b1); idle(4);
    rd(RG_RAW, 32'h0000_0010, "R6 no rise");
    set_pin(1, 1'b0); idle(4);
    rd(RG_RAW, 32'h0000_0012, "R6 fall");
    wr(RG_ICLR, 32'h0);
    rd(RG_RAW, 32'h0000_0012, "R11 zero write");
    wr(RG_ICLR, 32'h2);
    rd(RG_RAW, 32'h0000_0010, "R11 clear pin1");

    // R7: both edges on the top pin
    set_pin(31, 1'b1); idle(4);
    rd(RG_RAW, 32'h8000_0010, "R7 rise");
    wr(RG_ICLR, 32'h8000_0000);
    rd(RG_RAW, 32'h0000_0010, "R7 cleared");
    set_pin(31, 1'b0); idle(4);
    rd(RG_RAW, 32'h8000_0010, "R7 fall");
    wr(RG_ICLR, 32'h8000_0000);

    // R8: level high follows pin, clear has no effect
    set_pin(3, 1'b1); idle(3);
    rd(RG_RAW, 32'h0000_0018, "R8 high");
    wr(RG_ICLR, 32'h8);
    rd(RG_RAW, 32'h0000_0018, "R8 clear ignored");
    set_pin(3, 1'b0); idle(3);
    rd(RG_RAW, 32'h0000_0010, "R8 release");
    set_pin(4, 1'b1); idle(3);
    rd(RG_RAW, 32'h0, "R8 low inactive");

    // R10: disabled pin2
    set_pin(2, 1'b1); idle(4);
    set_pin(2, 1'b0); idle(4);
    rd(RG_RAW, 32'h0, "R10 disabled");

    // R9: mask an edge then release it
    wr(RG_MASK, 32'h1);
    set_pin(0, 1'b1); idle(4);
    rd(RG_RAW, 32'h1, "R9 raw masked");
    expect_item(KIND_IRQ, RG_MIS, 32'h0, "R9 irq masked");
    wr(RG_MASK, 32'h0);
    rd(RG_MIS, 32'h1, "R9 unmasked");
    expect_item(KIND_IRQ, RG_MIS, 32'h1, "R9 irq unmasked");
    wr(RG_ICLR, 32'h1);
    expect_item(KIND_IRQ, RG_MIS, 32'h0, "R11 irq cleared");

    // R12: debounce on pin5 (pins 0 and 4 are high now)
    wr(RG_DBEN, 32'h20);
    set_pin(5, 1'b1); idle(4);
    rd(RG_IN, 32'h11, "R12 held before ticks");
    pulse_tick(3);
    rd(RG_IN, 32'h11, "R12 three ticks");
    pulse_tick(1);
    rd(RG_IN, 32'h31, "R12 fourth tick");
    set_pin(5, 1'b0); idle(4);
    pulse_tick(2);
    rd(RG_IN, 32'h31, "R12 partial");
    set_pin(5, 1'b1); idle(4);
    set_pin(5, 1'b0); idle(4);
    pulse_tick(3);
    rd(RG_IN, 32'h31, "R12 restarted");
    pulse_tick(1);
    rd(RG_IN, 32'h11, "R12 accepted low");

    idle(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

endmodule